// File: doc/BRIEF.md
# Low Charge Alert Interrupt Logic

This block sits beside a state-of-charge engine and turns its results into a single active-low interrupt for the host. Each time the charge engine presents a new result, the block compares the integer-percent part of that result with a programmable threshold. When the charge is found below the threshold, a sticky alert flag is set and the alert line is pulled low. The alert line is meant to feed an open-drain pad.

The threshold is a 5-bit code held in a small configuration register. The code is stored inverted, so the percentage is 32 minus the code. The flag stays set until software clears it, and the block does not fire twice for one low-charge episode. After a trigger, the charge must first come back to the threshold or above before another trigger is possible. A doze input stands for the low-power sleep state. While it is high, results are not evaluated and the flag is held as it is.

Top module: `lca_alert`

## Requirements
- R1: A synchronous reset leaves the alert flag at 0, `alert_n` at 1 and the threshold code at 1Ch. The 1Ch code stands for 4%. The block comes out of reset armed.
- R2: The threshold in percent is 32 minus the 5-bit code. Code 00000 gives 32% and code 11111 gives 1%.
- R3: A sample is valid when `chg_valid` is high and `doze` is low. For a valid sample on an armed block, the comparison uses bits [15:8] of `chg_value`. If those bits are strictly less than the threshold, `alert_flag` goes to 1 and `alert_n` goes to 0 in the cycle after that clock edge. A value equal to the threshold does not trigger.
- R4: The alert is enabled from reset, so the first valid sample below the threshold triggers at once.
- R5: Once set, the flag and the low alert stay in place until a configuration write carries 0 in its flag bit. Samples at or above the threshold never clear the flag.
- R6: A configuration write with 1 in its flag bit never sets the flag.
- R7: A trigger disarms the block. Valid samples below the threshold leave it disarmed, even after the flag is cleared. A valid sample at or above the threshold re-arms it.
- R8: When `chg_valid` is low, the block ignores the value on `chg_value`.
- R9: While `doze` is high, samples are neither compared nor used to re-arm, and a pending flag is kept.
- R10: A configuration write loads `cfg_thr` into the threshold code, and `thr_code` reads the new code back in the next cycle. Without a write the code holds. Bits [7:0] of `chg_value` never affect a trigger.
- R11: In some cycles a trigger and a clearing write arrive together. In that case the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_valid | input | 1 | New charge result strobe |
| chg_value | input | 16 | Charge result; [15:8] whole percent, [7:0] fraction |
| doze | input | 1 | Low-power sleep state; halts evaluation |
| cfg_we | input | 1 | Configuration write enable |
| cfg_thr | input | 5 | Threshold code to write |
| cfg_flag_wd | input | 1 | Flag bit of the write; 0 clears, 1 has no effect |
| alert_n | output | 1 | Active-low alert, low while the flag is set |
| alert_flag | output | 1 | Sticky alert flag |
| thr_code | output | 5 | Current threshold code |

## Verification
Every result of this block comes from a single register stage. The flag, the alert line, the arming state and the threshold code all update on the clock edge that samples the strobe or the write. They are therefore due in the very next cycle. The bench drives each stimulus on a falling edge and advances its own model on the following rising edge. On the next falling edge it compares all three outputs with the model. In a cycle that carries both a write and a sample, the model compares against the old threshold, because the register only takes the new code at that edge.

// File: rtl/lca_pkg.sv
package lca_pkg;
    localparam int unsigned CHG_W     = 16;
    localparam int unsigned PCT_W     = 8;
    localparam int unsigned THR_W     = 5;
    localparam int unsigned THR_SPAN  = 1 << THR_W;
    localparam logic [THR_W-1:0] THR_RESET = 5'h1C;

    typedef logic [THR_W-1:0] thr_code_t;
    typedef logic [PCT_W-1:0] pct_t;

    typedef struct packed {
        logic      we;
        thr_code_t code;
        logic      flag_wd;
    } cfg_wr_t;

    typedef struct packed {
        logic strobe;
        logic below;
    } cmp_evt_t;

    typedef enum logic [1:0] {
        ARM_READY = 2'b01,
        ARM_SPENT = 2'b10
    } arm_state_t;

    function automatic pct_t thr_to_pct(input thr_code_t code);
        return pct_t'(THR_SPAN - int'(code));
    endfunction
endpackage

// File: rtl/lca_cfg_reg.sv
module lca_cfg_reg
    import lca_pkg::*;
#(
    parameter thr_code_t RESET_CODE = THR_RESET
) (
    input  logic      clk,
    input  logic      rst,
    input  cfg_wr_t   cfg_i,
    output thr_code_t thr_o
);
    thr_code_t thr_q;

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= RESET_CODE;
        else if (cfg_i.we)
            thr_q <= cfg_i.code;
    end

    assign thr_o = thr_q;
endmodule

// File: rtl/lca_compare.sv
module lca_compare
    import lca_pkg::*;
(
    input  logic             chg_valid,
    input  logic [CHG_W-1:0] chg_value,
    input  logic             doze,
    input  thr_code_t        thr_i,
    output cmp_evt_t         evt_o
);
    pct_t whole_pct;
    pct_t limit_pct;
    logic unused_frac_bits;

    assign whole_pct        = chg_value[CHG_W-1 -: PCT_W];
    assign unused_frac_bits = ^chg_value[CHG_W-PCT_W-1:0];
    assign limit_pct        = thr_to_pct(thr_i);

    always_comb begin
        evt_o.strobe = chg_valid & ~doze;
        evt_o.below  = whole_pct < limit_pct;
    end
endmodule

// File: rtl/lca_arm_ctrl.sv
module lca_arm_ctrl
    import lca_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmp_evt_t evt_i,
    input  logic     clr_req,
    output logic     flag_o,
    output logic     armed_o
);
    arm_state_t state_q, state_d;
    logic       flag_q, flag_d;
    logic       fire;

    assign fire = evt_i.strobe & evt_i.below & (state_q == ARM_READY);

    always_comb begin
        state_d = state_q;
        if (fire)
            state_d = ARM_SPENT;
        else if (evt_i.strobe && !evt_i.below)
            state_d = ARM_READY;

        flag_d = flag_q;
        if (fire)
            flag_d = 1'b1;
        else if (clr_req)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_READY;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = (state_q == ARM_READY);
endmodule

// File: rtl/lca_alert.sv
module lca_alert
    import lca_pkg::*;
#(
    parameter thr_code_t RESET_CODE = THR_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chg_valid,
    input  logic [CHG_W-1:0] chg_value,
    input  logic             doze,
    input  logic             cfg_we,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             cfg_flag_wd,
    output logic             alert_n,
    output logic             alert_flag,
    output logic [THR_W-1:0] thr_code
);
    cfg_wr_t   cfg_w;
    thr_code_t thr_w;
    cmp_evt_t  cmp_evt;
    logic      cmp_below;
    logic      armed_w;
    logic      flag_w;

    assign cfg_w = '{we: cfg_we, code: cfg_thr, flag_wd: cfg_flag_wd};

    lca_cfg_reg #(.RESET_CODE(RESET_CODE)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cfg_i (cfg_w),
        .thr_o (thr_w)
    );

    lca_compare u_cmp (
        .chg_valid (chg_valid),
        .chg_value (chg_value),
        .doze      (doze),
        .thr_i     (thr_w),
        .evt_o     (cmp_evt)
    );

    lca_arm_ctrl u_arm (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (cmp_evt),
        .clr_req (cfg_we & ~cfg_flag_wd),
        .flag_o  (flag_w),
        .armed_o (armed_w)
    );

    assign cmp_below  = cmp_evt.below;
    assign alert_flag = flag_w;
    assign alert_n    = ~flag_w;
    assign thr_code   = thr_w;
endmodule

// File: rtl/lca_alert_chk.sv
module lca_alert_chk
    import lca_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      chg_valid,
    input logic      doze,
    input logic      cfg_we,
    input logic      cfg_flag_wd,
    input logic      flag,
    input logic      alert_n,
    input thr_code_t thr,
    input logic      armed,
    input logic      below
);
    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!flag && alert_n && thr == THR_RESET && armed)); // R1

    AST_FIRES_WHEN_ARMED: assert property (@(posedge clk) disable iff (rst)
        (chg_valid && !doze && below && armed) |=> flag); // R3

    AST_HOLDS_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag && !(cfg_we && !cfg_flag_wd)) |=> flag); // R5

    AST_SETS_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(chg_valid && !doze)); // R9

    AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(armed)); // R7

    AST_THR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(thr)); // R10

    AST_DOZE_KEEPS_ARM: assert property (@(posedge clk) disable iff (rst)
        doze |=> $stable(armed)); // R9
endmodule

bind lca_alert lca_alert_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .chg_valid   (chg_valid),
    .doze        (doze),
    .cfg_we      (cfg_we),
    .cfg_flag_wd (cfg_flag_wd),
    .flag        (alert_flag),
    .alert_n     (alert_n),
    .thr         (thr_code),
    .armed       (armed_w),
    .below       (cmp_below)
);

// File: tb/lca_alert_test.sv
`timescale 1ns/1ps
module lca_alert_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chg_valid = 1'b0;
    logic [15:0] chg_value = '0;
    logic        doze = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_thr = '0;
    logic        cfg_flag_wd = 1'b1;
    logic        alert_n;
    logic        alert_flag;
    logic [4:0]  thr_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic       m_flag;
    logic       m_armed;
    logic [4:0] m_thr;

    always #4 clk = ~clk;

    lca_alert uut (
        .clk(clk), .rst(rst), .chg_valid(chg_valid), .chg_value(chg_value),
        .doze(doze), .cfg_we(cfg_we), .cfg_thr(cfg_thr), .cfg_flag_wd(cfg_flag_wd),
        .alert_n(alert_n), .alert_flag(alert_flag), .thr_code(thr_code)
    );

    function automatic int pct_of(input logic [4:0] code);
        return 32 - int'(code);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] val, input logic dz,
                        input logic we, input logic [4:0] code, input logic fwd,
                        input string tag);
        logic fire;
        logic below;
        chg_valid = v; chg_value = val; doze = dz;
        cfg_we = we; cfg_thr = code; cfg_flag_wd = fwd;
        @(posedge clk);
        below = int'(val[15:8]) < pct_of(m_thr);
        fire  = v && !dz && m_armed && below;
        if (v && !dz) m_armed = fire ? 1'b0 : (below ? m_armed : 1'b1);
        if (fire) m_flag = 1'b1;
        else if (we && !fwd) m_flag = 1'b0;
        if (we) m_thr = code;
        @(negedge clk);
        chk({tag, " flag"}, int'(alert_flag), int'(m_flag));
        chk({tag, " alert_n"}, int'(alert_n), int'(!m_flag));
        chk({tag, " thr"}, int'(thr_code), int'(m_thr));
    endtask

    task automatic sample(input int pct, input string tag);
        step(1'b1, {8'(pct), 8'h00}, 1'b0, 1'b0, m_thr, 1'b1, tag);
    endtask

    task automatic clear_flag(input string tag);
        step(1'b0, 16'h0, 1'b0, 1'b1, m_thr, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_flag = 1'b0; m_armed = 1'b1; m_thr = 5'h1C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 flag", int'(alert_flag), 0);
        chk("R1 alert_n", int'(alert_n), 1);
        chk("R1 thr", int'(thr_code), 28);

        // R3 R4: default 4%, equal does not fire, below fires
        sample(50, "R3 above");
        sample(4, "R3 equal");
        chk("R3 equal no fire", int'(alert_flag), 0);
        sample(3, "R4 first below");
        chk("R4 fired", int'(alert_flag), 1);
        // R5 held by high samples
        sample(60, "R5 high sample");
        chk("R5 held", int'(alert_flag), 1);
        clear_flag("R5 clear");
        chk("R5 cleared", int'(alert_flag), 0);
        // R7: fire, clear while below, no refire until rearm
        sample(2, "R7 fire");
        clear_flag("R7 clear");
        sample(2, "R7 still below");
        chk("R7 no refire", int'(alert_flag), 0);
        // R6 writing 1 does nothing
        step(1'b0, 16'h0, 1'b0, 1'b1, m_thr, 1'b1, "R6 write one");
        chk("R6 no set", int'(alert_flag), 0);
        sample(10, "R7 rearm");
        sample(2, "R7 refire");
        chk("R7 refired", int'(alert_flag), 1);
        clear_flag("R7 clear2");
        sample(10, "R8 rearm");
        // R8 strobe low ignored
        step(1'b0, 16'h0100, 1'b0, 1'b0, m_thr, 1'b1, "R8 no strobe");
        chk("R8 ignored", int'(alert_flag), 0);
        // R9 doze ignores samples
        step(1'b1, 16'h0100, 1'b1, 1'b0, m_thr, 1'b1, "R9 doze sample");
        chk("R9 ignored", int'(alert_flag), 0);
        sample(1, "R9 fire");
        for (int i = 0; i < 5; i++)
            step(1'b1, 16'h5000, 1'b1, 1'b0, m_thr, 1'b1, "R9 doze hold");
        chk("R9 kept", int'(alert_flag), 1);
        step(1'b1, 16'h0100, 1'b0, 1'b1, m_thr, 1'b0, "R9 clear");
        sample(40, "R2 rearm");
        // R2 code 0 -> 32%, code 31 -> 1%
        step(1'b0, 16'h0, 1'b0, 1'b1, 5'd0, 1'b1, "R10 write code0");
        chk("R10 readback", int'(thr_code), 0);
        sample(32, "R2 at 32");
        chk("R2 32 no fire", int'(alert_flag), 0);
        sample(31, "R2 below 32");
        chk("R2 fires 31", int'(alert_flag), 1);
        step(1'b0, 16'h0, 1'b0, 1'b1, 5'd31, 1'b0, "R2 code31");
        sample(1, "R2 at 1");
        chk("R2 1 no fire", int'(alert_flag), 0);
        sample(0, "R2 below 1");
        chk("R2 fires 0", int'(alert_flag), 1);
        // R10 fraction byte ignored
        step(1'b0, 16'h0, 1'b0, 1'b1, 5'h1C, 1'b0, "R10 back to 4");
        sample(9, "R10 rearm");
        step(1'b1, 16'h04FF, 1'b0, 1'b0, m_thr, 1'b1, "R10 frac");
        chk("R10 frac no fire", int'(alert_flag), 0);
        // R11 fire and clear together
        step(1'b1, 16'h0300, 1'b0, 1'b1, m_thr, 1'b0, "R11 set wins");
        chk("R11 flag", int'(alert_flag), 1);

        // random phase
        void'($urandom(32'd1357));
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] rv;
            rv = {8'($urandom % 40), 8'($urandom)};
            step(($urandom % 2) == 0, rv, ($urandom % 10) == 0,
                 ($urandom % 8) == 0, 5'($urandom), 1'($urandom),
                 "R3 R5 R7 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule